// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Turnaround Sequencer

This block runs transactions on a 24-bit bus where address and data share the same pins, with an external bidirectional transceiver in the path. It accepts single or burst read and write requests from an internal requester. Each transaction puts the address on the pins first and then transfers one or more data beats. The block drives the pin output enable, the value on the pins and the transceiver direction. On reads it passes the sampled pin value back to the requester.

Turnaround cycles are added only where the bus changes direction. Going from an address phase into read data, the direction output drops and the pins are released in that same cycle. After the last read beat there is a programmable number of hold cycles, so that a slow device can let go of the pins. Then comes exactly one idle cycle with the direction output high, before any new address may go out. Writes, addresses that follow writes, and later burst beats run back-to-back with no extra cycle.

States: `ST_IDLE` (nothing pending), `ST_ADDR` (address on pins), `ST_WDATA` (write beats), `ST_RDATA` (read beats, pins released), `ST_HOLD` (post-read hold), `ST_TURN` (one idle turnaround cycle). Transitions:
- IDLE→ADDR when a request is accepted.
- ADDR→WDATA or ADDR→RDATA, chosen by the latched write flag.
- WDATA→ADDR, when a new request is accepted at the last beat, or WDATA→IDLE otherwise.
- RDATA→HOLD when the hold count is nonzero, or RDATA→TURN otherwise.
- HOLD→TURN when the hold count is used up.
- TURN→ADDR when a request is accepted, or TURN→IDLE otherwise.

Top module: `mux_bus_seq`

## Requirements
- R1: After reset, and in idle with no request, `bus_dir`=1, `bus_oe`=0, `bus_out`=0, `req_ack`=0 and `req_take`=0.
- R2: A request (`req_valid`=1) is accepted in idle with a `req_take` pulse in the same cycle. The next cycle is the address phase: `bus_oe`=1, `bus_dir`=1 and `bus_out` equals the accepted `req_addr`.
- R3: On a write, data beats start in the cycle right after the address phase, with `bus_oe`=1, `bus_dir`=1 and `bus_out`=`beat_wdata`.
- R4: On a read, in the cycle after the address phase, `bus_dir` and `bus_oe` both go to 0. In the last cycle of each beat, `req_ack`=1 and `rd_data` equals `bus_in` from that cycle.
- R5: Each beat lasts `cfg_wait`+1 cycles, and `req_ack` pulses only in its last cycle. A transaction has `req_len`+1 beats (encoding 0..7 means 1..8 beats), and the beats follow one another with no gap.
- R6: After the last read beat, there are `cfg_hold` cycles (0..7) with `bus_dir`=0, `bus_oe`=0 and `req_ack`=0.
- R7: After the read hold there is exactly one turnaround cycle with `bus_dir`=1, `bus_oe`=0 and no acknowledge. A request present in that cycle is accepted, and its address phase follows in the next cycle.
- R8: If `req_valid` is high during the last write beat, the request is accepted in that cycle, and its address phase follows directly with no idle cycle.
- R9: `bus_oe` is never 1 while `bus_dir` is 0.
- R10: The request fields and `cfg_wait`/`cfg_hold` are sampled only when a request is accepted. Changing them later has no effect on the running transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request pending; held until `req_take` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Transaction address |
| req_len | input | 3 | Beats minus one |
| cfg_wait | input | 3 | Wait cycles per beat |
| cfg_hold | input | 3 | Hold cycles after a read |
| beat_wdata | input | 24 | Write data for the current beat |
| req_take | output | 1 | Request accepted this cycle |
| req_ack | output | 1 | Beat completes this cycle |
| rd_data | output | 24 | Read data, valid with `req_ack` on reads |
| bus_in | input | 24 | Pin value seen from the transceiver |
| bus_out | output | 24 | Value driven onto the pins |
| bus_oe | output | 1 | Pin output enable |
| bus_dir | output | 1 | Transceiver direction, 1 = outward |

## Verification
The assertions check, on every cycle, the rules that link direction and output enable:
- The output enable is never on while the direction is low.
- The direction falls only at the end of an address phase, and the pins are released in that same cycle.
- Every rise of the direction output is an idle cycle with no acknowledge.
- Every accept is followed by the accepted address on the pins.

Only the bench's scenarios can show the counted parts of the behaviour:
- the exact beat length and burst count;
- the number of hold cycles;
- read data being returned with its acknowledge;
- chained transactions going back-to-back after writes;
- configuration changes made mid-transaction having no effect.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WDATA,
        ST_RDATA,
        ST_HOLD,
        ST_TURN
    } mbus_state_e;

endpackage

// File: rtl/mbus_req_latch.sv
module mbus_req_latch #(
    parameter int DW     = 24,
    parameter int LEN_W  = 3,
    parameter int WAIT_W = 3,
    parameter int HOLD_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              req_write,
    input  logic [DW-1:0]     req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [WAIT_W-1:0] cfg_wait,
    input  logic [HOLD_W-1:0] cfg_hold,
    output logic              write_q,
    output logic [DW-1:0]     addr_q,
    output logic [LEN_W-1:0]  len_q,
    output logic [WAIT_W-1:0] wait_q,
    output logic [HOLD_W-1:0] hold_q
);

    // Fields and timing are frozen at accept; later input changes are ignored.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            write_q <= 1'b0;
            addr_q  <= '0;
            len_q   <= '0;
            wait_q  <= '0;
            hold_q  <= '0;
        end else if (take) begin
            write_q <= req_write;
            addr_q  <= req_addr;
            len_q   <= req_len;
            wait_q  <= cfg_wait;
            hold_q  <= cfg_hold;
        end
    end

endmodule

// File: rtl/mbus_beat_timer.sv
module mbus_beat_timer #(
    parameter int LEN_W  = 3,
    parameter int WAIT_W = 3,
    parameter int HOLD_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_data,
    input  logic              in_hold,
    input  logic [LEN_W-1:0]  len_q,
    input  logic [WAIT_W-1:0] wait_q,
    input  logic [HOLD_W-1:0] hold_q,
    output logic              beat_end,
    output logic              last_beat,
    output logic              hold_done
);

    localparam int HC_W = HOLD_W + 1;

    logic [WAIT_W-1:0] cyc_cnt;
    logic [LEN_W-1:0]  beat_cnt;
    logic [HOLD_W-1:0] hold_cnt;

    assign beat_end  = in_data && (cyc_cnt == wait_q);
    assign last_beat = (beat_cnt == len_q);
    assign hold_done = in_hold &&
                       ((HC_W'(hold_cnt) + HC_W'(1)) == HC_W'(hold_q));

    // Cycle position inside the current beat.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_cnt <= '0;
        end else if (!in_data || beat_end) begin
            cyc_cnt <= '0;
        end else begin
            cyc_cnt <= cyc_cnt + WAIT_W'(1);
        end
    end

    // Beat index inside the transaction.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_cnt <= '0;
        end else if (!in_data) begin
            beat_cnt <= '0;
        end else if (beat_end) begin
            beat_cnt <= beat_cnt + LEN_W'(1);
        end
    end

    // Cycles spent in post-read hold.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_cnt <= '0;
        end else if (!in_hold) begin
            hold_cnt <= '0;
        end else begin
            hold_cnt <= hold_cnt + HOLD_W'(1);
        end
    end

endmodule

// File: rtl/mbus_seq_fsm.sv
module mbus_seq_fsm
    import mbus_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic write_q,
    input  logic hold_nz,
    input  logic beat_end,
    input  logic last_beat,
    input  logic hold_done,
    output logic in_data,
    output logic in_hold,
    output logic drv_addr,
    output logic drv_wdata,
    output logic bus_oe,
    output logic bus_dir,
    output logic req_take,
    output logic req_ack
);

    mbus_state_e state_q, state_d;
    logic        xfer_done;

    assign xfer_done = beat_end && last_beat;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_ADDR;
            ST_ADDR:  state_d = write_q ? ST_WDATA : ST_RDATA;
            ST_WDATA: if (xfer_done) state_d = req_valid ? ST_ADDR : ST_IDLE;
            ST_RDATA: if (xfer_done) state_d = hold_nz ? ST_HOLD : ST_TURN;
            ST_HOLD:  if (hold_done) state_d = ST_TURN;
            ST_TURN:  state_d = req_valid ? ST_ADDR : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        in_data   = 1'b0;
        in_hold   = 1'b0;
        drv_addr  = 1'b0;
        drv_wdata = 1'b0;
        bus_oe    = 1'b0;
        bus_dir   = 1'b1;
        req_take  = 1'b0;
        req_ack   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_take = req_valid;
            end
            ST_ADDR: begin
                drv_addr = 1'b1;
                bus_oe   = 1'b1;
            end
            ST_WDATA: begin
                in_data   = 1'b1;
                drv_wdata = 1'b1;
                bus_oe    = 1'b1;
                req_ack   = beat_end;
                req_take  = req_valid && xfer_done;
            end
            ST_RDATA: begin
                in_data = 1'b1;
                bus_dir = 1'b0;
                req_ack = beat_end;
            end
            ST_HOLD: begin
                in_hold = 1'b1;
                bus_dir = 1'b0;
            end
            ST_TURN: begin
                req_take = req_valid;
            end
            default: begin
                bus_dir = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq #(
    parameter int DW     = 24,
    parameter int LEN_W  = 3,
    parameter int WAIT_W = 3,
    parameter int HOLD_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [DW-1:0]     req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [WAIT_W-1:0] cfg_wait,
    input  logic [HOLD_W-1:0] cfg_hold,
    input  logic [DW-1:0]     beat_wdata,
    output logic              req_take,
    output logic              req_ack,
    output logic [DW-1:0]     rd_data,
    input  logic [DW-1:0]     bus_in,
    output logic [DW-1:0]     bus_out,
    output logic              bus_oe,
    output logic              bus_dir
);

    logic              write_q;
    logic [DW-1:0]     addr_q;
    logic [LEN_W-1:0]  len_q;
    logic [WAIT_W-1:0] wait_q;
    logic [HOLD_W-1:0] hold_q;
    logic              beat_end, last_beat, hold_done;
    logic              in_data, in_hold, drv_addr, drv_wdata;

    mbus_req_latch #(
        .DW(DW), .LEN_W(LEN_W), .WAIT_W(WAIT_W), .HOLD_W(HOLD_W)
    ) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (req_take),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_len   (req_len),
        .cfg_wait  (cfg_wait),
        .cfg_hold  (cfg_hold),
        .write_q   (write_q),
        .addr_q    (addr_q),
        .len_q     (len_q),
        .wait_q    (wait_q),
        .hold_q    (hold_q)
    );

    mbus_beat_timer #(
        .LEN_W(LEN_W), .WAIT_W(WAIT_W), .HOLD_W(HOLD_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_data   (in_data),
        .in_hold   (in_hold),
        .len_q     (len_q),
        .wait_q    (wait_q),
        .hold_q    (hold_q),
        .beat_end  (beat_end),
        .last_beat (last_beat),
        .hold_done (hold_done)
    );

    mbus_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .write_q   (write_q),
        .hold_nz   (hold_q != '0),
        .beat_end  (beat_end),
        .last_beat (last_beat),
        .hold_done (hold_done),
        .in_data   (in_data),
        .in_hold   (in_hold),
        .drv_addr  (drv_addr),
        .drv_wdata (drv_wdata),
        .bus_oe    (bus_oe),
        .bus_dir   (bus_dir),
        .req_take  (req_take),
        .req_ack   (req_ack)
    );

    // Pin value: address in the address phase, beat data on writes, zero otherwise.
    always_comb begin
        bus_out = '0;
        if (drv_addr) begin
            bus_out = addr_q;
        end else if (drv_wdata) begin
            bus_out = beat_wdata;
        end
    end

    // Read data passes through on the sampling cycle of a read beat.
    assign rd_data = (req_ack && !bus_dir) ? bus_in : '0;

endmodule

// File: rtl/mbus_seq_chk.sv
module mbus_seq_chk #(
    parameter int DW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_take,
    input logic          req_ack,
    input logic [DW-1:0] req_addr,
    input logic [DW-1:0] beat_wdata,
    input logic [DW-1:0] bus_out,
    input logic          bus_oe,
    input logic          bus_dir
);

    a_r9_oe_needs_dir: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> bus_dir);

    a_r4_dir_fall_after_addr: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_dir) |-> ($past(bus_oe) && !bus_oe));

    a_r7_turn_is_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_dir) |-> (!bus_oe && !req_ack));

    a_r2_take_then_addr: assert property (@(posedge clk) disable iff (!rst_n)
        req_take |=> (bus_oe && bus_dir && (bus_out == $past(req_addr))));

    a_r3_write_ack_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ack && bus_dir) |-> (bus_oe && (bus_out == beat_wdata)));

endmodule

bind mux_bus_seq mbus_seq_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_take   (req_take),
    .req_ack    (req_ack),
    .req_addr   (req_addr),
    .beat_wdata (beat_wdata),
    .bus_out    (bus_out),
    .bus_oe     (bus_oe),
    .bus_dir    (bus_dir)
);

// File: tb/mux_bus_seq_test.sv
module mux_bus_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [23:0] req_addr = '0;
    logic [2:0]  req_len = '0;
    logic [2:0]  cfg_wait = '0;
    logic [2:0]  cfg_hold = '0;
    logic [23:0] beat_wdata = '0;
    logic [23:0] bus_in = '0;
    logic        req_take, req_ack, bus_oe, bus_dir;
    logic [23:0] rd_data, bus_out;

    int nchk = 0;
    int nfail = 0;

    // next-request fields used when chaining
    logic        nx_w;
    logic [23:0] nx_a;
    logic [2:0]  nx_len, nx_wt, nx_hd;

    always #10 clk = ~clk;

    mux_bus_seq uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_len(req_len), .cfg_wait(cfg_wait),
        .cfg_hold(cfg_hold), .beat_wdata(beat_wdata), .req_take(req_take),
        .req_ack(req_ack), .rd_data(rd_data), .bus_in(bus_in),
        .bus_out(bus_out), .bus_oe(bus_oe), .bus_dir(bus_dir)
    );

    // {write, addr, len, wait, hold}
    localparam logic [33:0] VEC [0:9] = '{
        {1'b1, 24'h123456, 3'd0, 3'd0, 3'd0},
        {1'b0, 24'hABCDEF, 3'd0, 3'd0, 3'd0},
        {1'b1, 24'h000010, 3'd3, 3'd0, 3'd2},
        {1'b0, 24'h800000, 3'd3, 3'd1, 3'd0},
        {1'b0, 24'h00FF00, 3'd0, 3'd2, 3'd3},
        {1'b1, 24'hFFFFFF, 3'd7, 3'd1, 3'd0},
        {1'b0, 24'h5A5A5A, 3'd7, 3'd0, 3'd7},
        {1'b1, 24'h0F0F0F, 3'd1, 3'd7, 3'd5},
        {1'b0, 24'h321000, 3'd2, 3'd7, 3'd1},
        {1'b0, 24'h000001, 3'd1, 3'd3, 3'd4}
    };

    function automatic logic [23:0] rdv(input logic [23:0] a, input int b);
        return a ^ (24'h0F1E2D + 24'(b) * 24'h010101);
    endfunction

    function automatic logic [23:0] wdv(input logic [23:0] a, input int b);
        return ~a + 24'(b) * 24'h000111;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive_req(input logic w, input logic [23:0] a, input logic [2:0] len,
                             input logic [2:0] wt, input logic [2:0] hd);
        req_valid = 1'b1;
        req_write = w;
        req_addr  = a;
        req_len   = len;
        cfg_wait  = wt;
        cfg_hold  = hd;
    endtask

    // Runs one transaction; pre=1 means it was already accepted.
    // chain=1 presents nx_* at the earliest accept point.
    task automatic do_txn(input logic w, input logic [23:0] a, input logic [2:0] len,
                          input logic [2:0] wt, input logic [2:0] hd,
                          input bit pre, input bit chain);
        if (!pre) begin
            @(negedge clk);
            drive_req(w, a, len, wt, hd);
            #1;
            chk("R2 take in idle", 32'(req_take), 32'd1);
        end
        @(negedge clk);
        req_valid = 1'b0;
        req_addr  = ~a;
        req_write = ~w;
        req_len   = ~len;
        cfg_wait  = ~wt;   // R10: changes after accept must be ignored
        cfg_hold  = ~hd;
        #1;
        chk("R2 addr oe", 32'(bus_oe), 32'd1);
        chk("R2 addr dir", 32'(bus_dir), 32'd1);
        chk("R2 addr value", 32'(bus_out), 32'(a));
        chk("R2 no ack in addr", 32'(req_ack), 32'd0);
        for (int b = 0; b <= int'(len); b++) begin
            for (int c = 0; c <= int'(wt); c++) begin
                @(negedge clk);
                beat_wdata = wdv(a, b);
                bus_in     = rdv(a, b);
                if (chain && w && b == int'(len) && c == int'(wt))
                    drive_req(nx_w, nx_a, nx_len, nx_wt, nx_hd);
                #1;
                chk("R5 R10 ack timing", 32'(req_ack), 32'(c == int'(wt)));
                if (w) begin
                    chk("R3 write oe", 32'(bus_oe), 32'd1);
                    chk("R3 write dir", 32'(bus_dir), 32'd1);
                    chk("R3 write data", 32'(bus_out), 32'(wdv(a, b)));
                end else begin
                    chk("R4 read dir low", 32'(bus_dir), 32'd0);
                    chk("R4 read oe off", 32'(bus_oe), 32'd0);
                    if (c == int'(wt))
                        chk("R4 read data", 32'(rd_data), 32'(rdv(a, b)));
                end
                if (chain && w && b == int'(len) && c == int'(wt))
                    chk("R8 accept at last write beat", 32'(req_take), 32'd1);
            end
        end
        if (!w) begin
            for (int h = 0; h < int'(hd); h++) begin
                @(negedge clk);
                #1;
                chk("R6 R10 hold dir", 32'(bus_dir), 32'd0);
                chk("R6 hold oe", 32'(bus_oe), 32'd0);
                chk("R6 hold ack", 32'(req_ack), 32'd0);
            end
            @(negedge clk);
            if (chain) drive_req(nx_w, nx_a, nx_len, nx_wt, nx_hd);
            #1;
            chk("R7 turn dir", 32'(bus_dir), 32'd1);
            chk("R7 turn oe", 32'(bus_oe), 32'd0);
            chk("R7 turn ack", 32'(req_ack), 32'd0);
            chk("R7 turn take", 32'(req_take), 32'(chain));
        end
    endtask

    task automatic chk_idle(input string tag);
        chk({tag, " dir"}, 32'(bus_dir), 32'd1);
        chk({tag, " oe"}, 32'(bus_oe), 32'd0);
        chk({tag, " out"}, 32'(bus_out), 32'd0);
        chk({tag, " ack"}, 32'(req_ack), 32'd0);
        chk({tag, " take"}, 32'(req_take), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        #5;
        chk_idle("R1 in reset");
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk_idle("R1 after reset");
        chk("R9 oe implies dir", 32'(bus_oe && !bus_dir), 32'd0);

        // table of vectors, each isolated by idle cycles
        for (int i = 0; i < 10; i++) begin
            do_txn(VEC[i][33], VEC[i][32:9], VEC[i][8:6], VEC[i][5:3], VEC[i][2:0], 1'b0, 1'b0);
            @(negedge clk);
            #1;
            chk_idle("R1 idle between");
        end

        // R8: write chained into write, then into read
        nx_w = 1'b1; nx_a = 24'h00AA00; nx_len = 3'd1; nx_wt = 3'd0; nx_hd = 3'd0;
        do_txn(1'b1, 24'h111111, 3'd2, 3'd1, 3'd0, 1'b0, 1'b1);
        nx_w = 1'b0; nx_a = 24'h0000BB; nx_len = 3'd1; nx_wt = 3'd1; nx_hd = 3'd2;
        do_txn(1'b1, 24'h00AA00, 3'd1, 3'd0, 3'd0, 1'b1, 1'b1);
        // R7: read chained through the turnaround into read, then write
        nx_w = 1'b0; nx_a = 24'hC0FFEE; nx_len = 3'd0; nx_wt = 3'd0; nx_hd = 3'd0;
        do_txn(1'b0, 24'h0000BB, 3'd1, 3'd1, 3'd2, 1'b1, 1'b1);
        nx_w = 1'b1; nx_a = 24'h777777; nx_len = 3'd0; nx_wt = 3'd2; nx_hd = 3'd0;
        do_txn(1'b0, 24'hC0FFEE, 3'd0, 3'd0, 3'd0, 1'b1, 1'b1);
        do_txn(1'b1, 24'h777777, 3'd0, 3'd2, 3'd0, 1'b1, 1'b0);
        @(negedge clk);
        #1;
        chk_idle("R1 idle after chain");

        // R1: reset in the middle of a read data phase
        @(negedge clk);
        drive_req(1'b0, 24'h424242, 3'd7, 3'd7, 3'd7);
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        #1;
        chk("R4 mid read dir", 32'(bus_dir), 32'd0);
        rst_n = 1'b0;
        #1;
        chk_idle("R1 async reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk_idle("R1 after second reset");

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule